// File: doc/BRIEF.md
# PS/2 Port Host Register Front End

This block gives a host processor a small register window onto a group of PS/2 ports, normally a keyboard port and a mouse port. Each port holds a control byte and a one-byte loopback store. Its status byte is assembled from live conditions, and it has its own receive queue for bytes arriving from the device. When the host writes an outgoing byte, the port offers it to the device side on a valid/ready handshake. Incoming bytes from the device land in the queue, and a host read of the data register takes the oldest one. The bit-level serial protocol and the attached device are not part of this block. Both sit behind the byte-wide handshakes.

Each port raises a pending line. In normal mode it follows the receive queue holding data. In loopback mode it follows the loopback store holding an unread byte. The wrapper ORs the pending lines into one interrupt output and also feeds that OR back to every port, so each status byte can report that some port in the group is pending. A diagnostic mode lets the two direction bits of control pull the reported line-state bits low, so software can exercise its line-state handling without a real device.

The bus is synchronous. Address bits above bit 7 pick the port, and bits [3:2] pick the register. A read started with `bus_rd` in one cycle returns its data on `bus_rdata` in the next cycle, and that value is held until the next read.

Top module: `ps2h_pair`

## Requirements
- R1: After synchronous reset, control reads 0x00, status reads 0xC0, no transmit byte is offered, and `irq` is low.
- R2: Address bit 8 selects the port (0 keyboard, 1 mouse) and bits [3:2] select the register. Reads at offset 0 return the port number (0 or 1), at 4 the receive data, at 8 the control byte and at 12 the status byte. Read data appears on `bus_rdata` in the cycle after `bus_rd`.
- R3: A write at offset 8 stores the byte unchanged. Its bits mean: 0x01 enable, 0x02 loopback, 0x20 diagnostic, 0x40 data direction, 0x80 clock direction.
- R4: With loopback set, a write at offset 4 stores the byte in the loopback store, marks it ready and raises the port's pending line. Nothing is offered to the device.
- R5: With loopback set, a read at offset 4 returns the loopback byte, clears its ready mark and drops the port's pending line.
- R6: With loopback clear, a write at offset 4 offers the byte on the port's transmit handshake. Valid and data stay stable until the device asserts ready.
- R7: With loopback clear, a read at offset 4 pops and returns the oldest queued byte. On an empty queue it returns 0x00 and pops nothing. Status bit 0x01 reflects whether the queue holds data.
- R8: Each receive queue holds 16 bytes. Receive ready is low while the queue is full, and a byte offered then is not stored.
- R9: Status bits 0x40 (data line) and 0x80 (clock line) read 1, except that with diagnostic set each one reads 0 when its direction bit (0x40 data, 0x80 clock) is clear.
- R10: Status bit 0x10 is 1 whenever any port is pending. `irq` is the OR of all ports' pending lines. With loopback clear, a port is pending exactly while its queue holds data.
- R11: Status bits 0x02, 0x04 and 0x08 always read 0. Writes at offsets 0 and 12 change no register, no status bit and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W (9) | Byte address; bit 8 picks the port, bits [3:2] the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after the strobe |
| dev_tx_valid | output | N_PORTS (2) | Outgoing byte offered, one bit per port |
| dev_tx_data | output | 8*N_PORTS (16) | Outgoing bytes, port p in bits [8p+7:8p] |
| dev_tx_ready | input | N_PORTS (2) | Device accepts the outgoing byte |
| dev_rx_valid | input | N_PORTS (2) | Device offers an incoming byte |
| dev_rx_data | input | 8*N_PORTS (16) | Incoming bytes, port p in bits [8p+7:8p] |
| dev_rx_ready | output | N_PORTS (2) | Receive queue has room |
| irq | output | 1 | OR of all ports' pending lines |

## Verification
The assertions watch, on every cycle, the properties that fit a short time window. These are: an offered transmit byte holding until it is accepted, the loopback store raising and dropping the pending line one cycle after the access, a full queue refusing input, an empty-queue read leaving the queue empty, and the fixed-zero and default line-state status bits. Other behaviour only shows across a scenario. That covers first-in-first-out order over a full queue, the register map seen through real bus reads, the diagnostic masking for each combination of direction bits, the combined-pending bit as seen from the other port, and offsets 0 and 12 ignoring writes. The bench's directed tasks cover that part.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      RI_IDENT = 2'd0,
      RI_DATA  = 2'd1,
      RI_CTRL  = 2'd2,
      RI_STAT  = 2'd3
   } reg_idx_e;

   localparam int CTL_ENABLE = 0;
   localparam int CTL_LOOP   = 1;
   localparam int CTL_DIAG   = 5;
   localparam int CTL_DDIR   = 6;
   localparam int CTL_CDIR   = 7;

   localparam int ST_RXNE    = 0;
   localparam int ST_TXBUSY  = 1;
   localparam int ST_TXERR   = 2;
   localparam int ST_PARERR  = 3;
   localparam int ST_ANYPEND = 4;
   localparam int ST_DLINE   = 6;
   localparam int ST_CLINE   = 7;

endpackage

// File: rtl/ps2h_rx_queue.sv
module ps2h_rx_queue #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] in_data,
   output logic             in_ready,
   input  logic             pop,
   output logic             out_valid,
   output logic [WIDTH-1:0] out_data
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("ps2h_rx_queue: DEPTH must be a power of two and at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("ps2h_rx_queue: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    count;
   logic             do_push, do_pop;

   assign in_ready  = (count != CW'(DEPTH));
   assign out_valid = (count != '0);
   assign out_data  = mem[rd_ptr];
   assign do_push   = in_valid && in_ready;
   assign do_pop    = pop && out_valid;

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= in_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
      count <= CW'(DEPTH));
   p_full_refuses_r8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_ready && !pop) |=> (count == CW'(DEPTH)));
   p_empty_pop_r7: assert property (@(posedge clk) disable iff (rst)
      (pop && !out_valid && !in_valid) |=> !out_valid);

endmodule

// File: rtl/ps2h_status.sv
module ps2h_status
   import ps2h_pkg::*;
(
   input  logic [BYTE_W-1:0] ctrl,
   input  logic              rx_not_empty,
   input  logic              any_pend,
   output logic [BYTE_W-1:0] status
);
   logic diag;

   assign diag = ctrl[CTL_DIAG];

   always_comb begin
      status              = '0;
      status[ST_RXNE]     = rx_not_empty;
      status[ST_TXBUSY]   = 1'b0;
      status[ST_TXERR]    = 1'b0;
      status[ST_PARERR]   = 1'b0;
      status[ST_ANYPEND]  = any_pend;
      status[ST_DLINE]    = !(diag && !ctrl[CTL_DDIR]);
      status[ST_CLINE]    = !(diag && !ctrl[CTL_CDIR]);
   end

endmodule

// File: rtl/ps2h_port.sv
module ps2h_port
   import ps2h_pkg::*;
#(
   parameter int PORT_ID  = 0,
   parameter int Q_DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel,
   input  logic              wr,
   input  logic              rd,
   input  logic [1:0]        reg_idx,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   input  logic              any_pend,
   output logic              pend,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_data,
   input  logic              tx_ready,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_data,
   output logic              rx_ready
);
   generate
      if (PORT_ID < 0 || PORT_ID > 255) begin : g_bad_id
         $error("ps2h_port: PORT_ID must fit in one byte");
      end
   endgenerate

   logic [BYTE_W-1:0] ctrl_q;
   logic [BYTE_W-1:0] lb_byte_q;
   logic              lb_ready_q;
   logic              loop;
   logic              wr_data, wr_ctrl, rd_data, rd_any;
   logic              q_valid, q_pop;
   logic [BYTE_W-1:0] q_head;
   logic [BYTE_W-1:0] status;
   logic              rxne;
   logic [BYTE_W-1:0] rd_value;

   assign loop    = ctrl_q[CTL_LOOP];
   assign wr_data = sel && wr && (reg_idx == RI_DATA);
   assign wr_ctrl = sel && wr && (reg_idx == RI_CTRL);
   assign rd_any  = sel && rd;
   assign rd_data = rd_any && (reg_idx == RI_DATA);
   assign q_pop   = rd_data && !loop;
   assign rxne    = loop ? lb_ready_q : q_valid;
   assign pend    = rxne;

   ps2h_rx_queue #(.WIDTH(BYTE_W), .DEPTH(Q_DEPTH)) u_rxq (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (rx_valid),
      .in_data   (rx_data),
      .in_ready  (rx_ready),
      .pop       (q_pop),
      .out_valid (q_valid),
      .out_data  (q_head)
   );

   ps2h_status u_stat (
      .ctrl         (ctrl_q),
      .rx_not_empty (rxne),
      .any_pend     (any_pend),
      .status       (status)
   );

   always_ff @(posedge clk) begin
      if (rst) ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= wdata;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         lb_byte_q  <= '0;
         lb_ready_q <= 1'b0;
      end else if (wr_data && loop) begin
         lb_byte_q  <= wdata;
         lb_ready_q <= 1'b1;
      end else if (rd_data && loop) begin
         lb_ready_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_valid <= 1'b0;
         tx_data  <= '0;
      end else if (wr_data && !loop) begin
         tx_valid <= 1'b1;
         tx_data  <= wdata;
      end else if (tx_ready) begin
         tx_valid <= 1'b0;
      end
   end

   always_comb begin
      unique case (reg_idx_e'(reg_idx))
         RI_IDENT: rd_value = BYTE_W'(PORT_ID);
         RI_DATA:  rd_value = loop ? lb_byte_q : (q_valid ? q_head : '0);
         RI_CTRL:  rd_value = ctrl_q;
         RI_STAT:  rd_value = status;
         default:  rd_value = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) rdata <= '0;
      else if (rd_any) rdata <= rd_value;
   end

   p_tx_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (tx_valid && !tx_ready && !wr_data) |=> (tx_valid && $stable(tx_data)));
   p_loop_no_tx_r4: assert property (@(posedge clk) disable iff (rst)
      (wr_data && loop && !tx_valid) |=> !tx_valid);
   p_loop_raise_r4: assert property (@(posedge clk) disable iff (rst)
      (wr_data && loop) |=> pend);
   p_loop_drop_r5: assert property (@(posedge clk) disable iff (rst)
      (rd_data && loop && !wr) |=> !pend);
   p_fixed_zero_r11: assert property (@(posedge clk) disable iff (rst)
      (rd_any && reg_idx == RI_STAT) |=> (rdata[3:1] == 3'b000));
   p_lines_default_r9: assert property (@(posedge clk) disable iff (rst)
      (rd_any && reg_idx == RI_STAT && !ctrl_q[CTL_DIAG]) |=> (rdata[7:6] == 2'b11));

endmodule

// File: rtl/ps2h_pair.sv
module ps2h_pair
   import ps2h_pkg::*;
#(
   parameter int N_PORTS    = 2,
   parameter int PORT_SHIFT = 8,
   parameter int ADDR_W     = 9,
   parameter int Q_DEPTH    = 16
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic                      bus_wr,
   input  logic [7:0]                bus_wdata,
   input  logic                      bus_rd,
   output logic [7:0]                bus_rdata,
   output logic [N_PORTS-1:0]        dev_tx_valid,
   output logic [8*N_PORTS-1:0]      dev_tx_data,
   input  logic [N_PORTS-1:0]        dev_tx_ready,
   input  logic [N_PORTS-1:0]        dev_rx_valid,
   input  logic [8*N_PORTS-1:0]      dev_rx_data,
   output logic [N_PORTS-1:0]        dev_rx_ready,
   output logic                      irq
);
   localparam int SEL_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

   generate
      if (N_PORTS < 2) begin : g_bad_ports
         $error("ps2h_pair: N_PORTS must be at least 2");
      end
      if (PORT_SHIFT < 4) begin : g_bad_shift
         $error("ps2h_pair: port select must sit above the register field");
      end
      if (ADDR_W < PORT_SHIFT + SEL_W) begin : g_bad_addr
         $error("ps2h_pair: ADDR_W too narrow for the port select");
      end
   endgenerate

   logic [SEL_W-1:0]  port_idx;
   logic [SEL_W-1:0]  rd_port_q;
   logic [1:0]        reg_idx;
   logic [N_PORTS-1:0] pend;
   logic              any_pend;
   logic [7:0]        port_rdata [N_PORTS];

   assign port_idx = bus_addr[PORT_SHIFT +: SEL_W];
   assign reg_idx  = bus_addr[3:2];
   assign any_pend = |pend;
   assign irq      = any_pend;

   genvar gi;
   generate
      for (gi = 0; gi < N_PORTS; gi++) begin : g_port
         ps2h_port #(.PORT_ID(gi), .Q_DEPTH(Q_DEPTH)) u_port (
            .clk      (clk),
            .rst      (rst),
            .sel      (port_idx == SEL_W'(gi)),
            .wr       (bus_wr),
            .rd       (bus_rd),
            .reg_idx  (reg_idx),
            .wdata    (bus_wdata),
            .rdata    (port_rdata[gi]),
            .any_pend (any_pend),
            .pend     (pend[gi]),
            .tx_valid (dev_tx_valid[gi]),
            .tx_data  (dev_tx_data[8*gi +: 8]),
            .tx_ready (dev_tx_ready[gi]),
            .rx_valid (dev_rx_valid[gi]),
            .rx_data  (dev_rx_data[8*gi +: 8]),
            .rx_ready (dev_rx_ready[gi])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) rd_port_q <= '0;
      else if (bus_rd) rd_port_q <= port_idx;
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < N_PORTS; i++) begin
         if (rd_port_q == SEL_W'(i)) bus_rdata = port_rdata[i];
      end
   end

   p_irq_after_reset_r1: assert property (@(posedge clk)
      $past(rst) |-> !irq);
   p_rx_pend_r10: assert property (@(posedge clk) disable iff (rst)
      (dev_rx_valid[0] && dev_rx_ready[0] && !g_port[0].u_port.ctrl_q[CTL_LOOP]
       && !bus_rd && !bus_wr) |=> irq);

endmodule

// File: tb/ps2h_pair_bench.sv
module ps2h_pair_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 2;
   localparam logic [8:0] KBD = 9'h000;
   localparam logic [8:0] MSE = 9'h100;

   logic          clk = 1'b0;
   logic          rst;
   logic [8:0]    bus_addr;
   logic          bus_wr;
   logic [7:0]    bus_wdata;
   logic          bus_rd;
   logic [7:0]    bus_rdata;
   logic [NP-1:0] dev_tx_valid;
   logic [8*NP-1:0] dev_tx_data;
   logic [NP-1:0] dev_tx_ready;
   logic [NP-1:0] dev_rx_valid;
   logic [8*NP-1:0] dev_rx_data;
   logic [NP-1:0] dev_rx_ready;
   logic          irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ps2h_pair u_ps2h_pair (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data),
      .dev_tx_ready(dev_tx_ready), .dev_rx_valid(dev_rx_valid),
      .dev_rx_data(dev_rx_data), .dev_rx_ready(dev_rx_ready), .irq(irq)
   );

   task automatic check(input string req, input int actual, input int expected);
      n_checks++;
      if (actual !== expected) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
      end
   endtask

   task automatic bus_write(input logic [8:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [8:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic dev_push(input int p, input logic [7:0] d);
      @(negedge clk);
      dev_rx_valid[p] = 1'b1;
      dev_rx_data[8*p +: 8] = d;
      @(negedge clk);
      dev_rx_valid[p] = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] v;
      bus_read(KBD + 9'h8, v); check("R1 ctrl after reset", v, 8'h00);
      bus_read(KBD + 9'hC, v); check("R1 status after reset", v, 8'hC0);
      check("R1 irq after reset", irq, 0);
      check("R1 no tx after reset", dev_tx_valid, 0);
      bus_read(KBD + 9'h0, v); check("R2 keyboard id", v, 0);
      bus_read(MSE + 9'h0, v); check("R2 mouse id", v, 1);
   endtask

   task automatic t_ctrl;
      logic [7:0] v;
      bus_write(MSE + 9'h8, 8'hE1);
      bus_read(MSE + 9'h8, v); check("R3 control stored as given", v, 8'hE1);
      bus_read(KBD + 9'h8, v); check("R2 other port control untouched", v, 8'h00);
      bus_write(MSE + 9'h8, 8'h00);
   endtask

   task automatic t_tx;
      bus_write(KBD + 9'h8, 8'h01);
      bus_write(KBD + 9'h4, 8'h5A);
      check("R6 tx valid", dev_tx_valid[0], 1);
      check("R6 tx data", dev_tx_data[7:0], 8'h5A);
      check("R6 mouse idle", dev_tx_valid[1], 0);
      repeat (3) @(negedge clk);
      check("R6 tx held", {dev_tx_valid[0], dev_tx_data[7:0]}, 9'h15A);
      dev_tx_ready[0] = 1'b1;
      @(negedge clk);
      dev_tx_ready[0] = 1'b0;
      check("R6 tx released", dev_tx_valid[0], 0);
   endtask

   task automatic t_rx;
      logic [7:0] v;
      dev_push(0, 8'h11); dev_push(0, 8'h22); dev_push(0, 8'h33);
      check("R10 irq on queued data", irq, 1);
      bus_read(KBD + 9'hC, v); check("R7 status with data", v, 8'hD1);
      bus_read(MSE + 9'hC, v); check("R10 combined bit on other port", v, 8'hD0);
      bus_read(KBD + 9'h4, v); check("R7 first byte", v, 8'h11);
      bus_read(KBD + 9'h4, v); check("R7 second byte", v, 8'h22);
      bus_read(KBD + 9'h4, v); check("R7 third byte", v, 8'h33);
      bus_read(KBD + 9'h4, v); check("R7 empty read", v, 8'h00);
      bus_read(KBD + 9'hC, v); check("R7 status empty", v, 8'hC0);
      check("R10 irq cleared", irq, 0);
   endtask

   task automatic t_full;
      logic [7:0] v;
      for (int i = 0; i < 16; i++) dev_push(1, 8'h40 + 8'(i));
      check("R8 ready low when full", dev_rx_ready[1], 0);
      dev_push(1, 8'hEE);
      for (int i = 0; i < 16; i++) begin
         bus_read(MSE + 9'h4, v); check("R8 fifo order", v, 8'h40 + i);
      end
      bus_read(MSE + 9'h4, v); check("R8 overflow byte dropped", v, 8'h00);
      check("R8 ready back", dev_rx_ready[1], 1);
   endtask

   task automatic t_loop;
      logic [7:0] v;
      bus_write(KBD + 9'h8, 8'h03);
      bus_write(KBD + 9'h4, 8'hA5);
      check("R4 nothing offered", dev_tx_valid[0], 0);
      check("R4 irq raised", irq, 1);
      bus_read(KBD + 9'hC, v); check("R4 status ready", v, 8'hD1);
      bus_read(KBD + 9'h4, v); check("R5 loopback byte", v, 8'hA5);
      check("R5 irq dropped", irq, 0);
      bus_read(KBD + 9'hC, v); check("R5 status cleared", v, 8'hC0);
      bus_write(KBD + 9'h8, 8'h01);
   endtask

   task automatic t_diag;
      logic [7:0] v;
      bus_write(MSE + 9'h8, 8'h20);
      bus_read(MSE + 9'hC, v); check("R9 diag both low", v, 8'h00);
      bus_write(MSE + 9'h8, 8'h60);
      bus_read(MSE + 9'hC, v); check("R9 diag data dir", v, 8'h40);
      bus_write(MSE + 9'h8, 8'hA0);
      bus_read(MSE + 9'hC, v); check("R9 diag clock dir", v, 8'h80);
      bus_write(MSE + 9'h8, 8'h00);
      bus_read(MSE + 9'hC, v); check("R9 default lines", v, 8'hC0);
   endtask

   task automatic t_ignored;
      logic [7:0] v;
      bus_write(KBD + 9'h0, 8'hFF);
      bus_write(KBD + 9'hC, 8'hFF);
      bus_read(KBD + 9'h8, v); check("R11 control untouched", v, 8'h01);
      bus_read(KBD + 9'hC, v); check("R11 status untouched", v, 8'hC0);
      check("R11 no tx", dev_tx_valid, 0);
      check("R11 irq low", irq, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
      dev_tx_ready = '0; dev_rx_valid = '0; dev_rx_data = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_ctrl();
      t_tx();
      t_rx();
      t_full();
      t_loop();
      t_diag();
      t_ignored();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule